// File: doc/BRIEF.md
# Solenoid Override Selector with Indicators

This block drives the enable lines of five solenoid valves. Each valve channel has two candidate sources: a command bit written by a host through a digital I/O port, and a toggle switch on the front panel. One shared override input picks the source for all five channels together. The override input is active low, so a 0 hands the valves to the panel switches. The five chosen bits leave the block as registered valve-enable outputs, which external relay drivers use.

The same chosen bits also light one indicator per valve. A further indicator shows when manual override is engaged. A lamp-test input forces every indicator on, so an operator can spot a dead lamp. Lamp test never reaches the valve outputs. All inputs are treated as asynchronous and pass through a two-flop synchronizer before any use. After that, one output register stage removes glitches when the source selection changes.

Top module: `solenoid_override_ctrl`

## Requirements
- R1: While the override input `ovr_n` is 1, each bit i of `valve_en` follows bit i of `host_cmd`.
- R2: While `ovr_n` is 0, each bit i of `valve_en` follows bit i of `panel_sw`.
- R3: While `lamp_test` is 0, `valve_led` equals `valve_en` bit for bit (1 = lit).
- R4: While `lamp_test` is 0, `ovr_led` is the inverse of `ovr_n` (lit while manual override is engaged).
- R5: While `lamp_test` is 1, all five `valve_led` bits and `ovr_led` are 1, whatever the valve and override states are.
- R6: `lamp_test` has no effect on `valve_en`.
- R7: While `rst_n` is low at a rising clock edge, all of `valve_en`, `valve_led` and `ovr_led` go to 0 after that edge, whatever the inputs are.
- R8: A change on any input reaches the outputs after exactly three rising clock edges: two synchronizer flops and one output register. After only two edges the outputs still show the old value.
- R9: The channels are independent: one valve's source bit affects only that valve's enable and indicator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_cmd | input | 5 | Valve commands from the host I/O port, asynchronous |
| panel_sw | input | 5 | Front-panel valve switches, asynchronous |
| ovr_n | input | 1 | Manual override, active low (0 = panel switches drive the valves) |
| lamp_test | input | 1 | Lamp test, active high, forces all indicators on |
| valve_en | output | 5 | Registered valve enables to the relay drivers (1 = open) |
| valve_led | output | 5 | Per-valve indicators, active high |
| ovr_led | output | 1 | Manual-override indicator, active high |

## Verification
The selection is tried with complementary host and switch patterns (10101 against 01010) in both override states. A swapped or stuck select therefore shows up as a bitwise mismatch rather than coinciding by chance. All-ones against all-zeros patterns show whether the override acts on the whole word. Walking-one patterns in each mode tell a crossed or shared channel apart from a correct one. Lamp test is toggled while the valve bits are held mixed, which separates indicator forcing from any leak onto the valve outputs. A timed input step checks that nothing moves before the third edge.

// File: rtl/solv_pkg.sv
// Package: shared constants for the solenoid override selector.
// Assumes: five valve channels and a two-flop synchronizer as defaults.
package solv_pkg;
    localparam int VALVE_COUNT   = 5;
    localparam int SYNC_DEPTH    = 2;
    // Level of the override input that selects the host source.
    localparam logic OVR_HOST_LVL = 1'b1;
endpackage

// File: rtl/solv_sync.sv
// Module: solv_sync
// What it does: moves a vector of asynchronous levels into the clk domain
// through a chain of STAGES flops per bit.
// Assumes: each bit is a slow level, so bits may cross on different cycles;
// the reset value is chosen per instance.
module solv_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    // First stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d_async;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each later stage re-samples the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/solv_select.sv
// Module: solv_select
// What it does: picks the host or panel word from the override level and
// registers it onto the valve enables; it also exports the pick for the
// indicator stage.
// Assumes: all inputs are already synchronous to clk.
module solv_select #(
    parameter int N = solv_pkg::VALVE_COUNT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] host_s,
    input  logic [N-1:0] panel_s,
    input  logic         ovr_n_s,
    output logic [N-1:0] sel_nxt,
    output logic [N-1:0] valve_en
);
    // Per-channel source choice.
    genvar c;
    generate
        for (c = 0; c < N; c++) begin : g_ch
            assign sel_nxt[c] = (ovr_n_s == solv_pkg::OVR_HOST_LVL) ? host_s[c] : panel_s[c];
        end
    endgenerate

    // Output register: all valves closed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) valve_en <= '0;
        else        valve_en <= sel_nxt;
    end

    p_host_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_n_s |=> (valve_en == $past(host_s)));
    p_panel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_n_s |=> (valve_en == $past(panel_s)));
    p_reset_r7: assert property (@(posedge clk)
        !rst_n |=> (valve_en == '0));
endmodule

// File: rtl/solv_indicator.sv
// Module: solv_indicator
// What it does: registers the per-valve and override indicators; lamp test
// forces all of them on.
// Assumes: inputs are synchronous; ovr_n_s is active low while the LEDs
// are active high.
module solv_indicator #(
    parameter int N = solv_pkg::VALVE_COUNT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sel_nxt,
    input  logic         ovr_n_s,
    input  logic         lamp_s,
    output logic [N-1:0] valve_led,
    output logic         ovr_led
);
    // Indicator register with lamp-test override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valve_led <= '0;
            ovr_led   <= 1'b0;
        end else begin
            valve_led <= lamp_s ? {N{1'b1}} : sel_nxt;
            ovr_led   <= lamp_s | ~ovr_n_s;
        end
    end

    p_lamp_all_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lamp_s |=> ((&valve_led) && ovr_led));
    p_ovr_led_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !lamp_s |=> (ovr_led == !$past(ovr_n_s)));
endmodule

// File: rtl/solenoid_override_ctrl.sv
// Module: solenoid_override_ctrl (top)
// What it does: synchronizes the host, panel, override and lamp-test inputs,
// selects the valve source and drives the valve enables and indicators.
// Assumes: every input is asynchronous; reset is synchronous and active low.
module solenoid_override_ctrl #(
    parameter int N      = solv_pkg::VALVE_COUNT,
    parameter int STAGES = solv_pkg::SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] host_cmd,
    input  logic [N-1:0] panel_sw,
    input  logic         ovr_n,
    input  logic         lamp_test,
    output logic [N-1:0] valve_en,
    output logic [N-1:0] valve_led,
    output logic         ovr_led
);
    logic [N-1:0] host_s, panel_s, sel_nxt;
    logic         ovr_n_s, lamp_s;

    solv_sync #(.WIDTH(N), .STAGES(STAGES), .RST_VAL('0)) u_sync_host (
        .clk(clk), .rst_n(rst_n), .d_async(host_cmd), .q_sync(host_s));
    solv_sync #(.WIDTH(N), .STAGES(STAGES), .RST_VAL('0)) u_sync_panel (
        .clk(clk), .rst_n(rst_n), .d_async(panel_sw), .q_sync(panel_s));
    solv_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_sync_ovr (
        .clk(clk), .rst_n(rst_n), .d_async(ovr_n), .q_sync(ovr_n_s));
    solv_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_sync_lamp (
        .clk(clk), .rst_n(rst_n), .d_async(lamp_test), .q_sync(lamp_s));

    solv_select #(.N(N)) u_select (
        .clk(clk), .rst_n(rst_n), .host_s(host_s), .panel_s(panel_s),
        .ovr_n_s(ovr_n_s), .sel_nxt(sel_nxt), .valve_en(valve_en));

    solv_indicator #(.N(N)) u_ind (
        .clk(clk), .rst_n(rst_n), .sel_nxt(sel_nxt), .ovr_n_s(ovr_n_s),
        .lamp_s(lamp_s), .valve_led(valve_led), .ovr_led(ovr_led));

    p_led_tracks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lamp_s |=> (valve_led == valve_en));
    p_lamp_no_valve_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(host_s) && $stable(panel_s) && $stable(ovr_n_s)) |=> $stable(valve_en));
endmodule

// File: tb/solenoid_override_ctrl_tb.sv
module solenoid_override_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] host_cmd = '0, panel_sw = '0;
    logic       ovr_n = 1'b1, lamp_test = 1'b0;
    logic [4:0] valve_en, valve_led;
    logic       ovr_led;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    solenoid_override_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .host_cmd(host_cmd), .panel_sw(panel_sw),
        .ovr_n(ovr_n), .lamp_test(lamp_test), .valve_en(valve_en),
        .valve_led(valve_led), .ovr_led(ovr_led));

    // {host, panel, ovr_n, lamp, exp valve_en, exp valve_led, exp ovr_led}
    localparam logic [22:0] VEC [9] = '{
        {5'b10101, 5'b01010, 1'b1, 1'b0, 5'b10101, 5'b10101, 1'b0},
        {5'b10101, 5'b01010, 1'b0, 1'b0, 5'b01010, 5'b01010, 1'b1},
        {5'b11111, 5'b00000, 1'b1, 1'b0, 5'b11111, 5'b11111, 1'b0},
        {5'b11111, 5'b00000, 1'b0, 1'b0, 5'b00000, 5'b00000, 1'b1},
        {5'b00001, 5'b10000, 1'b1, 1'b1, 5'b00001, 5'b11111, 1'b1},
        {5'b00001, 5'b10000, 1'b0, 1'b1, 5'b10000, 5'b11111, 1'b1},
        {5'b01100, 5'b00011, 1'b0, 1'b0, 5'b00011, 5'b00011, 1'b1},
        {5'b00000, 5'b11111, 1'b1, 1'b0, 5'b00000, 5'b00000, 1'b0},
        {5'b10010, 5'b01001, 1'b1, 1'b1, 5'b10010, 5'b11111, 1'b1}
    };

    task automatic chk(input string req, input logic [10:0] exp);
        logic [10:0] act;
        act = {valve_en, valve_led, ovr_led};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got valve=%b led=%b ovr=%b expected valve=%b led=%b ovr=%b",
                     req, act[10:6], act[5:1], act[0], exp[10:6], exp[5:1], exp[0]);
        end
    endtask

    task automatic drive(input logic [4:0] h, input logic [4:0] s, input logic o, input logic l);
        @(negedge clk);
        host_cmd = h; panel_sw = s; ovr_n = o; lamp_test = l;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R7: reset forces outputs low even with active inputs.
        host_cmd = 5'b11111; lamp_test = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R7 reset state", 11'b0);
        rst_n = 1'b1;
        drive(5'b00000, 5'b00000, 1'b1, 1'b0);
        settle();

        // R1 R2 R3 R4 R5: table walk.
        for (int i = 0; i < 9; i++) begin
            drive(VEC[i][22:18], VEC[i][17:13], VEC[i][12], VEC[i][11]);
            settle();
            chk($sformatf("R1/R2/R3/R4/R5 vector %0d", i), VEC[i][10:0]);
        end

        // R8: latency is exactly three edges.
        drive(5'b00000, 5'b00000, 1'b1, 1'b0);
        settle();
        drive(5'b11011, 5'b00000, 1'b1, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R8 unchanged after two edges", 11'b00000_00000_0);
        @(posedge clk);
        @(negedge clk);
        chk("R8 updated after third edge", 11'b11011_11011_0);

        // R6: lamp test toggled with valves held.
        drive(5'b01101, 5'b10010, 1'b0, 1'b1);
        settle();
        chk("R6 lamp on, panel valves kept", 11'b10010_11111_1);
        drive(5'b01101, 5'b10010, 1'b0, 1'b0);
        settle();
        chk("R6 lamp off, panel valves kept", 11'b10010_10010_1);
        drive(5'b01101, 5'b10010, 1'b1, 1'b1);
        settle();
        chk("R6 lamp on, host valves kept", 11'b01101_11111_1);

        // R9: walking one per channel, both sources.
        for (int c = 0; c < 5; c++) begin
            logic [4:0] one;
            one = 5'b00001 << c;
            drive(one, ~one, 1'b1, 1'b0);
            settle();
            chk($sformatf("R9 host channel %0d", c), {one, one, 1'b0});
            drive(~one, one, 1'b0, 1'b0);
            settle();
            chk($sformatf("R9 panel channel %0d", c), {one, one, 1'b1});
        end

        // R7: reset asserted mid-run clears outputs.
        drive(5'b11111, 5'b11111, 1'b0, 1'b1);
        settle();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R7 mid-run reset", 11'b0);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule